// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block is a down-counting interval timer for raising a periodic interrupt. A power-of-two prescaler divides the system clock into ticks. A 16-bit counter starts from a programmed modulus and steps down by one on every tick. When the counter underflows it either reloads from the modulus or rolls over to all ones, and it sets an interrupt flag. Software programs the timer through a plain synchronous write port with one enable per byte lane. A combinational read port returns the control word, the modulus or the live count.

The block also models how each kind of register write moves the timing phase. Any write that enables the control word's upper lane restarts the prescaler from zero, even when the prescaler value written is the same as the old one. A write to the lower lane alone leaves the prescaler and the counter where they are, so software should clear the flag that way. In overwrite mode a modulus write restarts the count at once and clears the flag. A debug-halt input can freeze counting when software has allowed it.

Register addresses: 0 is the control word, 1 is the modulus and 2 is the counter. The counter is read-only, so writes to address 2 have no effect. Reads of address 3 return zero.

Top module: `pit_timer`

## Requirements
- R1: With the prescaler field at control bits 11:8 set to P and modulus M, the flag is set every (M+1)·2^P clock cycles. At the moment the flag is set, the counter holds M when the reload bit (control bit 1) is 1. P=15 gives a divide of 32768.
- R2: With the reload bit 0, the counter goes from zero to 0xFFFF on underflow and keeps counting down from there.
- R3: The flag (control bit 2) is set at every underflow. A lower-lane control write with bit 2 at 1 clears it. The irq output equals the flag AND the interrupt-enable bit (control bit 3).
- R4: When an underflow and a flag-clear write happen on the same clock edge, the flag stays set.
- R5: A control write that enables only byte lane 0 leaves the prescaler phase and the counter phase unchanged.
- R6: Any control write that enables byte lane 1 restarts the prescaler from zero, even when the prescaler field is rewritten with its current value. This lengthens the running period by the prescaler count that is discarded.
- R7: With the overwrite bit (control bit 4) set, a modulus write loads the new value into the counter on the same edge and clears the flag. With that bit clear, a modulus write changes only the modulus.
- R8: While the enable bit (control bit 0) is 0, the prescaler is held at zero and the counter follows the modulus one cycle behind it. Counting after enable therefore starts from the modulus.
- R9: While dbg_halt is 1 and the halt-allow bit (control bit 5) is 1, the counter and the prescaler keep their values. When the halt-allow bit is 0, dbg_halt has no effect.
- R10: After reset the control word reads 0, the modulus and the counter read 0xFFFF, and irq is 0. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 modulus, 2 counter (ignored) |
| wr_data | input | CNT_W | Write data |
| wr_be | input | CNT_W/8 | Per-byte write enables |
| rd_addr | input | 2 | Read address |
| rd_data | output | CNT_W | Combinational read data |
| dbg_halt | input | 1 | Debug halt request |
| irq | output | 1 | Interrupt request: flag AND interrupt enable |

## Verification
The assertions take four things for granted. Reset is applied before the first write. The prescaler field changes only through a write that enables lane 1, which also restarts the prescaler, so the prescaler count can never exceed the new divide. dbg_halt and all write inputs change away from the rising edge. The stimulus drives every input on falling edges and changes the prescaler only with full-word control writes. It never uses a modulus of zero, so a flag set and the software clear that follows it never fall on the same edge, except in the one test that places them there on purpose.

// File: rtl/pit_pkg.sv
package pit_pkg;
   localparam logic [1:0] ADR_CSR = 2'd0;
   localparam logic [1:0] ADR_MOD = 2'd1;
   localparam logic [1:0] ADR_CNT = 2'd2;

   localparam int B_EN   = 0;
   localparam int B_RLD  = 1;
   localparam int B_FLAG = 2;
   localparam int B_IEN  = 3;
   localparam int B_OVW  = 4;
   localparam int B_HEN  = 5;
   localparam int PRE_LSB = 8;

   typedef struct packed {
      logic hen;
      logic ovw;
      logic ien;
      logic rld;
      logic en;
   } ctl_t;
endpackage

// File: rtl/pit_regs.sv
module pit_regs
   import pit_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int PRE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_addr,
   input  logic [CNT_W-1:0]   wr_data,
   input  logic [CNT_W/8-1:0] wr_be,
   input  logic               flag_set,
   output ctl_t               ctl,
   output logic [PRE_W-1:0]   pre,
   output logic               flag,
   output logic [CNT_W-1:0]   mod,
   output logic [CNT_W-1:0]   load_val,
   output logic               ovw_load,
   output logic               psc_restart
);
   localparam int BYTES = CNT_W / 8;

   logic             csr_wr;
   logic             mod_wr;
   logic             flag_clr;
   logic [CNT_W-1:0] mod_next;
   logic             unused_bits;

   assign csr_wr = wr_en && (wr_addr == ADR_CSR);
   assign mod_wr = wr_en && (wr_addr == ADR_MOD);
   assign unused_bits = ^{wr_data[CNT_W-1:PRE_LSB+PRE_W], wr_data[7:6]};

   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      assign mod_next[b*8 +: 8] = wr_be[b] ? wr_data[b*8 +: 8] : mod[b*8 +: 8];
   end

   assign ovw_load    = mod_wr && ctl.ovw;
   assign load_val    = mod_next;
   assign psc_restart = (csr_wr && wr_be[1]) || ovw_load;
   assign flag_clr    = (csr_wr && wr_be[0] && wr_data[B_FLAG]) || ovw_load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl  <= '0;
         pre  <= '0;
         flag <= 1'b0;
         mod  <= '1;
      end else begin
         if (csr_wr && wr_be[0]) begin
            ctl.en  <= wr_data[B_EN];
            ctl.rld <= wr_data[B_RLD];
            ctl.ien <= wr_data[B_IEN];
            ctl.ovw <= wr_data[B_OVW];
            ctl.hen <= wr_data[B_HEN];
         end
         if (csr_wr && wr_be[1])
            pre <= wr_data[PRE_LSB +: PRE_W];
         if (mod_wr)
            mod <= mod_next;
         if (flag_set)
            flag <= 1'b1;
         else if (flag_clr)
            flag <= 1'b0;
      end
   end

   // R4
   flag_set_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_set |=> flag);

   // R7
   ovw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADR_MOD && ctl.ovw && !flag_set) |=> !flag);
endmodule

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
   parameter int PRE_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             frz,
   input  logic             restart,
   input  logic [PRE_W-1:0] pre,
   output logic             tick
);
   localparam int PSC_W = (1 << PRE_W) - 1;

   logic [PSC_W-1:0] psc_q;
   logic [PSC_W-1:0] mask;

   always_comb mask = ~({PSC_W{1'b1}} << pre);

   assign tick = en && !frz && !restart && (psc_q == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         psc_q <= '0;
      else if (!en || restart)
         psc_q <= '0;
      else if (!frz)
         psc_q <= (psc_q == mask) ? '0 : psc_q + 1'b1;
   end

   // R1
   psc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      psc_q <= mask);

   // R9
   psc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frz && en && !restart) |=> $stable(psc_q));
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             rld,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] mod,
   output logic [CNT_W-1:0] cnt,
   output logic             flag_set
);
   logic at_zero;

   assign at_zero  = (cnt == '0);
   assign flag_set = en && tick && at_zero && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '1;
      else if (load)
         cnt <= load_val;
      else if (!en)
         cnt <= mod;
      else if (tick)
         cnt <= at_zero ? (rld ? mod : '1) : cnt - 1'b1;
   end

   // R8
   dis_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !load) |=> cnt == $past(mod));
endmodule

// File: rtl/pit_timer.sv
module pit_timer
   import pit_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int PRE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_addr,
   input  logic [CNT_W-1:0]   wr_data,
   input  logic [CNT_W/8-1:0] wr_be,
   input  logic [1:0]         rd_addr,
   output logic [CNT_W-1:0]   rd_data,
   input  logic               dbg_halt,
   output logic               irq
);
   if (CNT_W % 8 != 0 || CNT_W < 16) begin : g_bad_width
      $error("CNT_W must be a multiple of 8 and at least 16");
   end
   if (PRE_W < 1 || PRE_W > 5) begin : g_bad_pre
      $error("PRE_W must lie in 1..5");
   end

   ctl_t             ctl;
   logic [PRE_W-1:0] pre;
   logic             flag;
   logic [CNT_W-1:0] mod;
   logic [CNT_W-1:0] load_val;
   logic             ovw_load;
   logic             psc_restart;
   logic             flag_set;
   logic             tick;
   logic             frz;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] csr_view;

   assign frz = dbg_halt && ctl.hen;

   pit_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_be(wr_be), .flag_set(flag_set),
      .ctl(ctl), .pre(pre), .flag(flag), .mod(mod), .load_val(load_val),
      .ovw_load(ovw_load), .psc_restart(psc_restart)
   );

   pit_prescaler #(.PRE_W(PRE_W)) i_psc (
      .clk(clk), .rst_n(rst_n), .en(ctl.en), .frz(frz),
      .restart(psc_restart), .pre(pre), .tick(tick)
   );

   pit_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk(clk), .rst_n(rst_n), .en(ctl.en), .rld(ctl.rld), .tick(tick),
      .load(ovw_load), .load_val(load_val), .mod(mod), .cnt(cnt),
      .flag_set(flag_set)
   );

   always_comb begin
      csr_view = '0;
      csr_view[B_EN]   = ctl.en;
      csr_view[B_RLD]  = ctl.rld;
      csr_view[B_FLAG] = flag;
      csr_view[B_IEN]  = ctl.ien;
      csr_view[B_OVW]  = ctl.ovw;
      csr_view[B_HEN]  = ctl.hen;
      csr_view[PRE_LSB +: PRE_W] = pre;
   end

   always_comb begin
      case (rd_addr)
         ADR_CSR: rd_data = csr_view;
         ADR_MOD: rd_data = mod;
         ADR_CNT: rd_data = cnt;
         default: rd_data = '0;
      endcase
   end

   assign irq = flag && ctl.ien;

   // R9
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_halt && ctl.hen && ctl.en && !ovw_load) |=> $stable(cnt));
endmodule

// File: tb/test_pit_timer.sv
module test_pit_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [15:0] wr_data = 16'h0;
   logic [1:0]  wr_be = 2'b00;
   logic [1:0]  rd_addr = 2'd0;
   logic [15:0] rd_data;
   logic        dbg_halt = 1'b0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   localparam logic [1:0] A_CSR = 2'd0, A_MOD = 2'd1, A_CNT = 2'd2;

   // {prescale field, modulus, expected period in cycles}
   localparam logic [35:0] VEC [0:5] = '{
      {4'd0, 16'd1,  16'd2},
      {4'd1, 16'd1,  16'd4},
      {4'd3, 16'd4,  16'd40},
      {4'd2, 16'd9,  16'd40},
      {4'd0, 16'd99, 16'd100},
      {4'd4, 16'd3,  16'd64}
   };

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pit_timer i_pit_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_be(wr_be), .rd_addr(rd_addr),
      .rd_data(rd_data), .dbg_halt(dbg_halt), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic [1:0] be);
      wr_addr = a; wr_data = d; wr_be = be; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_be = 2'b00;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic wait_irq(input string req);
      int n = 0;
      while (irq !== 1'b1 && n < 5000) begin
         @(negedge clk);
         n++;
      end
      if (n >= 5000) begin
         checks++; errors++;
         $display("FAIL %s irq timeout actual=0 expected=1", req);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] v, c1, c2, m;
      logic [3:0]  p;
      int t0, t1;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset values
      rd(A_CSR, v); chk("R10 csr", v, 16'h0000);
      rd(A_MOD, v); chk("R10 mod", v, 16'hFFFF);
      rd(A_CNT, v); chk("R10 cnt", v, 16'hFFFF);
      chk("R10 irq", irq, 1'b0);

      // R1 period table
      for (int i = 0; i < 6; i++) begin
         p = VEC[i][35:32]; m = VEC[i][31:16];
         wr(A_CSR, 16'h0004, 2'b11);
         wr(A_MOD, m, 2'b11);
         wr(A_CSR, {4'h0, p, 8'h0F}, 2'b11);
         wait_irq("R1");
         wr(A_CSR, 16'h000F, 2'b01);
         wait_irq("R1");
         t0 = cyc;
         rd(A_CNT, v); chk("R1 reload value", v, m);
         wr(A_CSR, 16'h000F, 2'b01);
         wait_irq("R1");
         t1 = cyc;
         chk("R1 period", t1 - t0, VEC[i][15:0]);
         wr(A_CSR, 16'h000F, 2'b01);
      end

      // R5 and R6: phase effect of lower-lane vs full-word control writes
      wr(A_CSR, 16'h0004, 2'b11);
      wr(A_MOD, 16'd9, 2'b11);
      wr(A_CSR, 16'h030F, 2'b11);
      wait_irq("R5");
      wr(A_CSR, 16'h000F, 2'b01);
      wait_irq("R5");
      t0 = cyc;
      repeat (3) @(negedge clk);
      wr(A_CSR, 16'h000F, 2'b01);
      wait_irq("R5");
      t1 = cyc;
      chk("R5 lower-lane write keeps period", t1 - t0, 80);
      t0 = cyc;
      repeat (3) @(negedge clk);
      wr(A_CSR, 16'h030F, 2'b11);
      wait_irq("R6");
      t1 = cyc;
      chk("R6 same-value prescaler write restarts", t1 - t0, 84);

      // R4 set beats clear, R3 clear and irq gating
      wr(A_CSR, 16'h0004, 2'b11);
      wr(A_MOD, 16'd4, 2'b11);
      wr(A_CSR, 16'h000F, 2'b11);
      wait_irq("R4");
      wr(A_CSR, 16'h000F, 2'b01);
      repeat (3) @(negedge clk);
      wr(A_CSR, 16'h000F, 2'b01);
      chk("R4 set wins over clear", irq, 1'b1);
      wr(A_CSR, 16'h000F, 2'b01);
      chk("R3 flag cleared", irq, 1'b0);
      wr(A_CSR, 16'h0007, 2'b01);
      repeat (12) @(negedge clk);
      chk("R3 irq masked", irq, 1'b0);
      rd(A_CSR, v); chk("R3 flag still set", v[2], 1'b1);

      // R2 rollover without reload
      wr(A_CSR, 16'h0004, 2'b11);
      wr(A_MOD, 16'd5, 2'b11);
      wr(A_CSR, 16'h000D, 2'b11);
      wait_irq("R2");
      rd(A_CNT, v); chk("R2 rollover", v, 16'hFFFF);
      @(negedge clk);
      rd(A_CNT, v); chk("R2 continues down", v, 16'hFFFE);

      // R7 overwrite mode
      wr(A_CSR, 16'h0004, 2'b11);
      wr(A_MOD, 16'd9, 2'b11);
      wr(A_CSR, 16'h001F, 2'b11);
      wait_irq("R7");
      repeat (2) @(negedge clk);
      wr(A_MOD, 16'd20, 2'b11);
      rd(A_CNT, v); chk("R7 immediate load", v, 16'd20);
      chk("R7 flag cleared", irq, 1'b0);
      wr(A_CSR, 16'h0004, 2'b11);
      wr(A_MOD, 16'd100, 2'b11);
      wr(A_CSR, 16'h0F0B, 2'b11);
      wr(A_MOD, 16'd50, 2'b11);
      rd(A_CNT, v); chk("R7 no overwrite keeps count", v, 16'd100);
      rd(A_MOD, v); chk("R7 modulus updated", v, 16'd50);

      // R8 disabled counter follows modulus
      wr(A_CSR, 16'h0004, 2'b11);
      wr(A_MOD, 16'h1234, 2'b11);
      @(negedge clk);
      rd(A_CNT, v); chk("R8 follows modulus", v, 16'h1234);
      wr(A_CSR, 16'h0F03, 2'b11);
      @(negedge clk);
      rd(A_CNT, v); chk("R8 starts from modulus", v, 16'h1234);

      // R9 debug halt
      wr(A_CSR, 16'h0004, 2'b11);
      wr(A_MOD, 16'd1000, 2'b11);
      wr(A_CSR, 16'h002B, 2'b11);
      repeat (5) @(negedge clk);
      dbg_halt = 1'b1;
      @(negedge clk);
      rd(A_CNT, c1);
      repeat (10) @(negedge clk);
      rd(A_CNT, c2);
      chk("R9 frozen", c2, c1);
      dbg_halt = 1'b0;
      repeat (3) @(negedge clk);
      rd(A_CNT, v); chk("R9 resumes", v, c2 - 16'd3);
      wr(A_CSR, 16'h000B, 2'b01);
      dbg_halt = 1'b1;
      rd(A_CNT, c1);
      repeat (4) @(negedge clk);
      rd(A_CNT, v); chk("R9 halt ignored when not allowed", v, c1 - 16'd4);
      dbg_halt = 1'b0;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule